// File: doc/BRIEF.md
# Trimmable RTC Seconds Counter

This block keeps wall-clock time as a 32-bit count of seconds. Its reference is a 32.768 kHz event stream. That stream arrives either directly, as a one-cycle enable on the system clock, or as a 4.194304 MHz enable stream that the block divides by 128. A select bit picks the source. A down-counting predivider turns reference events into second boundaries. On each boundary the block raises a one-cycle tick and advances the seconds count.

The seconds are grouped in blocks of 64. Within each block, the second with index 63 divides by a programmable trim value, and every other second divides by the nominal value 0x7FFF. Moving the trim up lengthens that one second and slows the clock. Moving it down shortens the second and speeds the clock up, so software can correct a reference that is slightly off frequency.

Software uses a small write-only register port. It can load the seconds count, which also restarts the predivider, set the trim and choose the reference source.

Top module: `rtc_trim_clock`

## Requirements
- R1: After reset, `seconds` is 0 and `sec_tick` is low. The trim value is NOMINAL (0x7FFF by default) and the direct reference (select 0) is in use.
- R2: Writing address 2 sets the reference select from bit 0 of `wr_data`. With select 0, each cycle with `slow_en` high is one reference event. With select 1, the divided `fast_en` stream supplies the reference events and `slow_en` is ignored.
- R3: With select 1, the block produces one reference event for every 128 cycles that have `fast_en` high. The event comes in the cycle after the 128th such `fast_en`.
- R4: The block counts every second except index 63 as NOMINAL+1 reference events. At the edge of the last event, `sec_tick` goes high for one cycle and `seconds` increases by 1 on the same edge.
- R5: A 6-bit index counts the seconds since the last restart, modulo 64. The second with index 63 lasts trim+1 reference events.
- R6: A trim above NOMINAL makes second 63 longer than the others, and a trim below NOMINAL makes it shorter.
- R7: Writing address 0 loads `wr_data` into `seconds` on the next edge. That write also reloads the predivider with NOMINAL, clears the index to 0 and suppresses any tick in that cycle.
- R8: `seconds` changes only on a tick or a load. It wraps from 0xFFFFFFFF to 0.
- R9: Writing address 1 stores `wr_data[15:0]` as the trim. A new trim first affects the next reload of the predivider, not the second in progress. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle enable per 32.768 kHz reference event |
| fast_en | input | 1 | One-cycle enable per 4.194304 MHz event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 seconds, 1 trim, 2 select |
| wr_data | input | 32 | Register write data |
| seconds | output | 32 | Current seconds count |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |

## Verification
The bench first runs the direct reference with an enable in every cycle. This makes the length of each second equal to a cycle count, so a nominal second, a trimmed-up second 63 and a trimmed-down second 63 can each be measured and told apart. Random sparse `slow_en` patterns, mixed with random trim and select writes, separate a predivider that counts reference events from one that counts clock cycles. They also show whether a trim write reaches the second in progress or only the next reload. A random `fast_en` stream with select 1 exposes a wrong divide ratio in the prescaler. Loads near 0xFFFFFFFF, and loads that coincide with a terminal count, check the wrap and the priority of a load over a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned RTC_SEC_W    = 32;
    localparam int unsigned RTC_TRIM_W   = 16;
    localparam int unsigned RTC_IDX_W    = 6;
    localparam int unsigned RTC_DIV_LOG2 = 7;
    localparam int unsigned RTC_NOMINAL  = 32'h7FFF;

    typedef enum logic [1:0] {
        ADDR_SECONDS = 2'd0,
        ADDR_TRIM    = 2'd1,
        ADDR_REFSEL  = 2'd2,
        ADDR_UNUSED  = 2'd3
    } rtc_addr_e;
endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
    import rtc_pkg::*;
#(
    parameter int unsigned SEC_W   = RTC_SEC_W,
    parameter int unsigned TRIM_W  = RTC_TRIM_W,
    parameter int unsigned NOMINAL = RTC_NOMINAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [SEC_W-1:0]  wr_data,
    output logic [TRIM_W-1:0] trim,
    output logic              ref_sel,
    output logic              load_req,
    output logic [SEC_W-1:0]  load_val
);
    localparam logic [TRIM_W-1:0] NOM_V = TRIM_W'(NOMINAL);

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic              sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (rtc_addr_e'(wr_addr))
                ADDR_TRIM:   cfg_d.trim = wr_data[TRIM_W-1:0];
                ADDR_REFSEL: cfg_d.sel  = wr_data[0];
                default:     cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.trim <= NOM_V;
            cfg_q.sel  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign trim     = cfg_q.trim;
    assign ref_sel  = cfg_q.sel;
    assign load_req = wr_en && (rtc_addr_e'(wr_addr) == ADDR_SECONDS);
    assign load_val = wr_data;
endmodule

// File: rtl/rtc_ref_prescale.sv
module rtc_ref_prescale
    import rtc_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = RTC_DIV_LOG2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_en,
    output logic ref_pulse
);
    localparam logic [DIV_LOG2-1:0] LAST = '1;

    typedef struct packed {
        logic [DIV_LOG2-1:0] cnt;
        logic                pulse;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d       = pre_q;
        pre_d.pulse = fast_en && (pre_q.cnt == LAST);
        if (fast_en) begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign ref_pulse = pre_q.pulse;
endmodule

// File: rtl/rtc_predivider.sv
module rtc_predivider
    import rtc_pkg::*;
#(
    parameter int unsigned TRIM_W  = RTC_TRIM_W,
    parameter int unsigned IDX_W   = RTC_IDX_W,
    parameter int unsigned NOMINAL = RTC_NOMINAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              restart,
    input  logic [TRIM_W-1:0] trim,
    output logic              wrap,
    output logic              sec_tick
);
    localparam logic [TRIM_W-1:0] NOM_V    = TRIM_W'(NOMINAL);
    localparam logic [IDX_W-1:0]  IDX_LAST = '1;

    typedef struct packed {
        logic [TRIM_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic              tick;
    } div_t;

    div_t div_d, div_q;
    logic at_zero;

    assign at_zero = (div_q.cnt == '0);

    always_comb begin
        div_d      = div_q;
        div_d.tick = 1'b0;
        if (restart) begin
            div_d.cnt = NOM_V;
            div_d.idx = '0;
        end else if (ref_tick) begin
            if (at_zero) begin
                div_d.tick = 1'b1;
                div_d.idx  = div_q.idx + 1'b1;
                div_d.cnt  = (div_d.idx == IDX_LAST) ? trim : NOM_V;
            end else begin
                div_d.cnt = div_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt  <= NOM_V;
            div_q.idx  <= '0;
            div_q.tick <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign wrap     = ref_tick && at_zero && !restart;
    assign sec_tick = div_q.tick;
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_pkg::*;
#(
    parameter int unsigned SEC_W = RTC_SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             inc,
    output logic [SEC_W-1:0] count
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_t;

    sec_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (load) begin
            sec_d.sec = load_val;
        end else if (inc) begin
            sec_d.sec = sec_q.sec + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign count = sec_q.sec;
endmodule

// File: rtl/rtc_trim_clock.sv
module rtc_trim_clock
    import rtc_pkg::*;
#(
    parameter int unsigned TRIM_W   = RTC_TRIM_W,
    parameter int unsigned IDX_W    = RTC_IDX_W,
    parameter int unsigned DIV_LOG2 = RTC_DIV_LOG2,
    parameter int unsigned NOMINAL  = RTC_NOMINAL
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_en,
    input  logic        fast_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] seconds,
    output logic        sec_tick
);
    localparam int unsigned SEC_W = 32;

    logic [TRIM_W-1:0] trim;
    logic              ref_sel;
    logic              load_req;
    logic [SEC_W-1:0]  load_val;
    logic              pre_pulse;
    logic              ref_tick;
    logic              wrap;

    rtc_cfg_regs #(
        .SEC_W  (SEC_W),
        .TRIM_W (TRIM_W),
        .NOMINAL(NOMINAL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trim    (trim),
        .ref_sel (ref_sel),
        .load_req(load_req),
        .load_val(load_val)
    );

    rtc_ref_prescale #(
        .DIV_LOG2(DIV_LOG2)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_en  (fast_en),
        .ref_pulse(pre_pulse)
    );

    assign ref_tick = ref_sel ? pre_pulse : slow_en;

    rtc_predivider #(
        .TRIM_W (TRIM_W),
        .IDX_W  (IDX_W),
        .NOMINAL(NOMINAL)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .restart (load_req),
        .trim    (trim),
        .wrap    (wrap),
        .sec_tick(sec_tick)
    );

    rtc_seconds #(
        .SEC_W(SEC_W)
    ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_req),
        .load_val(load_val),
        .inc     (wrap),
        .count   (seconds)
    );
endmodule

// File: rtl/rtc_trim_clock_chk.sv
module rtc_trim_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fast_en,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        pre_pulse,
    input logic [31:0] seconds,
    input logic        sec_tick
);
    logic ld;
    assign ld = wr_en && (wr_addr == 2'd0);

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sec_tick) |-> (seconds == $past(seconds) + 32'd1));

    // R7
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld)) |-> ((seconds == $past(wr_data)) && !sec_tick));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld) && !sec_tick) |-> (seconds == $past(seconds)));

    // R3
    pre_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pre_pulse) |-> $past(fast_en));
endmodule

bind rtc_trim_clock rtc_trim_clock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_en  (fast_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pre_pulse(pre_pulse),
    .seconds  (seconds),
    .sec_tick (sec_tick)
);

// File: tb/tb_rtc_trim_clock.sv
module tb_rtc_trim_clock;
    localparam int NOM   = 7;
    localparam int IDXM  = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0, fast_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] seconds;
    logic        sec_tick;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model state
    int unsigned m_pre, m_cnt, m_idx, m_trim;
    bit          m_pulse, m_tick, m_sel;
    logic [31:0] m_sec;

    rtc_trim_clock #(.TRIM_W(16), .IDX_W(6), .DIV_LOG2(7), .NOMINAL(NOM)) dut (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .fast_en(fast_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .seconds(seconds), .sec_tick(sec_tick));

    always #5 clk = ~clk;

    function automatic int unsigned reload_for(int unsigned idx, int unsigned trim);
        return (idx == IDXM) ? trim : NOM;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pre = 0; m_pulse = 0; m_cnt = NOM; m_idx = 0; m_trim = NOM;
        m_tick = 0; m_sel = 0; m_sec = '0;
    endtask

    // one cycle: drive, advance model at the edge, compare at negedge
    task automatic step(string req, bit s, bit f, bit w, logic [1:0] a, logic [31:0] d);
        bit ref_ev, ld;
        slow_en = s; fast_en = f; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        ref_ev = m_sel ? m_pulse : s;
        m_pulse = f && (m_pre == 127);
        if (f) m_pre = (m_pre + 1) % 128;
        ld = w && (a == 2'd0);
        m_tick = 0;
        if (ld) begin
            m_sec = d; m_cnt = NOM; m_idx = 0;
        end else if (ref_ev) begin
            if (m_cnt == 0) begin
                m_tick = 1; m_sec = m_sec + 1;
                m_idx = (m_idx + 1) % 64;
                m_cnt = reload_for(m_idx, m_trim);
            end else m_cnt = m_cnt - 1;
        end
        if (w && a == 2'd1) m_trim = d[15:0];
        if (w && a == 2'd2) m_sel = d[0];
        @(negedge clk);
        check(req, seconds, m_sec);
        check(req, {31'd0, sec_tick}, {31'd0, m_tick});
    endtask

    // directed: length in cycles of the second that ends at target (enable every cycle)
    task automatic measure(string req, logic [31:0] from, int exp_len);
        int n = 0;
        while (seconds != from) step(req, 1, 0, 0, 2'd0, '0);
        while (seconds == from && n < 100000) begin
            step(req, 1, 0, 0, 2'd0, '0);
            n++;
        end
        check(req, n, exp_len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", seconds, 32'd0);
        check("R1", {31'd0, sec_tick}, 32'd0);
        rst_n = 1'b1;

        // R4 nominal second length with an event every cycle
        measure("R4", 32'd1, NOM + 1);
        // R1 R5 default trim equals nominal: second 63 also NOM+1
        step("R7", 0, 0, 1, 2'd0, 32'd0);
        measure("R1", 32'd63, NOM + 1);

        // R6 trim up slows: second 63 longer
        step("R9", 0, 0, 1, 2'd1, 32'd12);
        step("R7", 0, 0, 1, 2'd0, 32'd0);
        measure("R5", 32'd62, NOM + 1);
        measure("R6", 32'd63, 13);
        // R6 trim down speeds: second 63 shorter
        step("R9", 0, 0, 1, 2'd1, 32'd3);
        step("R7", 0, 0, 1, 2'd0, 32'd100);
        measure("R6", 32'd163, 4);
        measure("R5", 32'd164, NOM + 1);

        // R9 address 3 write has no effect
        step("R9", 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        measure("R9", seconds, NOM + 1);

        // R8 wrap
        step("R7", 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        measure("R8", 32'hFFFF_FFFF, NOM + 1);
        check("R8", seconds, 32'd0);

        // R7 load on the terminal-count cycle wins over the tick
        step("R7", 0, 0, 1, 2'd0, 32'd50);
        repeat (NOM) step("R7", 1, 0, 0, 2'd0, '0);
        step("R7", 1, 0, 1, 2'd0, 32'd900);
        check("R7", seconds, 32'd900);

        // R2 R3 divided fast reference, slow_en toggling and ignored
        step("R2", 0, 0, 1, 2'd2, 32'd1);
        for (int i = 0; i < 12000; i++)
            step("R3", 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), 0, 2'd0, '0);
        step("R2", 0, 0, 1, 2'd2, 32'd0);

        // R2 R4 R9 random sparse slow events with random register writes
        for (int i = 0; i < 40000; i++) begin
            bit w = ($urandom_range(0, 199) == 0);
            logic [1:0] a = 2'($urandom_range(0, 3));
            logic [31:0] d = (a == 2'd1) ? 32'($urandom_range(0, 20))
                           : (a == 2'd0) ? (32'hFFFF_FFF0 + 32'($urandom_range(0, 15)))
                           : 32'($urandom);
            step("R9", ($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), w, a, d);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule